// File: doc/BRIEF.md
# Unary Bubble Sorter for Single-Bit Lanes

This block takes a vector of independent one-bit lanes and rearranges the set bits so that they gather at one end. When X lanes are high at the input, the output shows exactly X high lanes, occupying output positions 1 through X (vector index 0 through X-1). The result does not depend on where the high lanes were. In effect the block turns a scattered bit pattern into a thermometer code whose length is the population count of the input.

The network is purely combinational: no clock, no state and no handshake. It is a stack of bubble passes. Each pass is a ripple chain of two-input compare-exchange cells. A cell sends the OR of its pair toward the top position and the AND toward the bottom. Pass p settles output position p+1, and each pass has one cell fewer than the one before. A parameter chooses how many passes are built. A reduced count gives a partial sort, in which only the leading positions are guaranteed, at a lower gate cost.

Top module: `unary_bubble_sorter`

## Requirements
- R1: A compare-exchange cell with lane inputs (a, b) drives its upper output with a OR b and its lower output with a AND b. For WIDTH=2 the block is a single cell: input 00 gives 00, inputs 01 and 10 give sorted_o[0]=1 and sorted_o[1]=0, and input 11 gives 11.
- R2: For every PASSES setting, the number of high bits on sorted_o equals the number of high bits on bits_i.
- R3: With PASSES=WIDTH-1 (the default), sorted_o has bit i high exactly when i is less than the population count of bits_i. Index 0 is output position 1.
- R4: With any PASSES value P, for every i below P, sorted_o[i] is high exactly when i is less than the population count of bits_i.
- R5: With PASSES=0, sorted_o equals bits_i.
- R6: sorted_o depends only on the present bits_i. A new input appears at the output in the same time step, without any clock edge.
- R7: A single pass (PASSES=1) drives sorted_o[0] with the OR of all input lanes.
- R8: Each pass leaves the positions it has already settled unchanged. The pass with index p sets position p to the OR of positions p through WIDTH-1 of its own input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | WIDTH | Unsorted single-bit lanes |
| sorted_o | output | WIDTH | Sorted lanes; set bits packed from index 0 upward |

## Verification
The full sorter is driven with every pattern on ten lanes and every pattern on eight lanes. This checks the thermometer form and the preserved count for each population count from empty to full, wherever the set bits sit. Constrained random vectors and directed corners are added on top: all lanes low, all lanes high, a lone bit at either end, and alternating bits. The corners separate an error in the ripple direction from an error in a cell's OR/AND roles.

The same stimulus also drives several builds of the block:
- a three-pass build, which shows that only the leading positions are promised and that nothing is lost from the tail;
- a one-pass build, which isolates the OR chain;
- a zero-pass build, which must be a plain wire-through;
- a two-lane build, which exposes the bare compare-exchange truth table.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;

  // Widest lane vector the helper functions accept.
  localparam int unsigned SN_MAX_W = 64;

  // Count of set lanes in a zero-extended vector.
  function automatic int unsigned ones_count(input logic [SN_MAX_W-1:0] v);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < int'(SN_MAX_W); i++) begin
      acc = acc + int'(v[i]);
    end
    return acc;
  endfunction

  // Thermometer code with the low 'len' bits set.
  function automatic logic [SN_MAX_W-1:0] unary_mask(input int unsigned len);
    logic [SN_MAX_W-1:0] m;
    for (int i = 0; i < int'(SN_MAX_W); i++) begin
      m[i] = (i < int'(len));
    end
    return m;
  endfunction

endpackage

// File: rtl/ce_cell.sv
// Two-input compare-exchange for one-bit keys.
module ce_cell (
  input  logic a_i,
  input  logic b_i,
  output logic hi_o,
  output logic lo_o
);
  assign hi_o = a_i | b_i;
  assign lo_o = a_i & b_i;
endmodule

// File: rtl/bubble_pass.sv
// One bubble pass: a ripple of compare-exchange cells running from the
// bottom lane up to lane FIRST. It floats the OR of lanes FIRST..WIDTH-1
// into lane FIRST. Lanes below FIRST pass straight through.
module bubble_pass #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned FIRST = 0
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [WIDTH-1:0] vec_o
);
  localparam int unsigned NCELL = WIDTH - 1 - FIRST;

  // Value being carried upward; index j holds what enters lane j from below.
  logic [WIDTH-1:FIRST] carry;

  assign carry[WIDTH-1] = vec_i[WIDTH-1];

  for (genvar i = 0; i < FIRST; i++) begin : g_keep
    assign vec_o[i] = vec_i[i];
  end

  for (genvar j = FIRST + 1; j < WIDTH; j++) begin : g_cell
    ce_cell u_cell (
      .a_i  (vec_i[j-1]),
      .b_i  (carry[j]),
      .hi_o (carry[j-1]),
      .lo_o (vec_o[j])
    );
  end

  assign vec_o[FIRST] = carry[FIRST];

endmodule

// File: rtl/unary_bubble_sorter.sv
// Stack of PASSES bubble passes; pass p settles lane p.
module unary_bubble_sorter #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned PASSES = WIDTH - 1
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic [WIDTH-1:0] sorted_o
);
  localparam int unsigned NSTAGE  = PASSES + 1;
  localparam int unsigned NCELLS  = PASSES * (2 * WIDTH - 1 - PASSES) / 2;
  localparam int unsigned NGATES  = 2 * NCELLS;

  // Lane vector at every stage boundary, stage 0 = inputs.
  logic [NSTAGE*WIDTH-1:0] stage_flat;

  assign stage_flat[WIDTH-1:0] = bits_i;

  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    bubble_pass #(
      .WIDTH (WIDTH),
      .FIRST (p)
    ) u_pass (
      .vec_i (stage_flat[p*WIDTH +: WIDTH]),
      .vec_o (stage_flat[(p+1)*WIDTH +: WIDTH])
    );
  end

  assign sorted_o = stage_flat[PASSES*WIDTH +: WIDTH];

endmodule

// File: rtl/unary_bubble_sorter_chk.sv
module unary_bubble_sorter_chk
  import sortnet_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned PASSES = WIDTH - 1
) (
  input logic [WIDTH-1:0]              bits_i,
  input logic [WIDTH-1:0]              sorted_o,
  input logic [(PASSES+1)*WIDTH-1:0]   stage_flat
);
  always_comb begin
    logic [SN_MAX_W-1:0] in_w;
    logic [SN_MAX_W-1:0] out_w;
    logic [SN_MAX_W-1:0] cur;
    logic [SN_MAX_W-1:0] nxt;
    int unsigned         cnt;
    in_w  = SN_MAX_W'(bits_i);
    out_w = SN_MAX_W'(sorted_o);
    cnt   = ones_count(in_w);

    // R2
    popcount_kept_chk: assert (ones_count(out_w) == cnt)
      else $error("set-lane count changed");

    for (int i = 0; i < int'(PASSES); i++) begin
      // R4
      head_settled_chk: assert (out_w[i] == (i < int'(cnt)))
        else $error("settled lane %0d wrong", i);
    end

    if (PASSES == WIDTH - 1) begin
      // R3
      full_sorted_chk: assert (out_w == unary_mask(cnt))
        else $error("output not a thermometer code");
    end

    for (int p = 0; p < int'(PASSES); p++) begin
      cur = SN_MAX_W'(stage_flat[p*WIDTH +: WIDTH]);
      nxt = SN_MAX_W'(stage_flat[(p+1)*WIDTH +: WIDTH]);
      // R8
      pass_top_chk: assert (nxt[p] == (|(cur >> p)))
        else $error("pass %0d did not float the OR", p);
      // R8
      pass_prefix_chk: assert ((nxt & unary_mask(p)) == (cur & unary_mask(p)))
        else $error("pass %0d disturbed settled lanes", p);
    end
  end
endmodule

bind unary_bubble_sorter unary_bubble_sorter_chk #(
  .WIDTH  (WIDTH),
  .PASSES (PASSES)
) u_chk (
  .bits_i     (bits_i),
  .sorted_o   (sorted_o),
  .stage_flat (stage_flat)
);

// File: tb/tb_unary_bubble_sorter.sv
`timescale 1ns/1ps
module tb_unary_bubble_sorter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [9:0] in10;
  logic [7:0] in8;
  logic [1:0] in2;
  logic [9:0] out10;
  logic [7:0] out8, outp3, outp1, outp0;
  logic [1:0] out2;

  unary_bubble_sorter #(.WIDTH(10)) dut (.bits_i(in10), .sorted_o(out10));
  unary_bubble_sorter #(.WIDTH(8)) dut_w8 (.bits_i(in8), .sorted_o(out8));
  unary_bubble_sorter #(.WIDTH(8), .PASSES(3)) dut_p3 (.bits_i(in8), .sorted_o(outp3));
  unary_bubble_sorter #(.WIDTH(8), .PASSES(1)) dut_p1 (.bits_i(in8), .sorted_o(outp1));
  unary_bubble_sorter #(.WIDTH(8), .PASSES(0)) dut_p0 (.bits_i(in8), .sorted_o(outp0));
  unary_bubble_sorter #(.WIDTH(2)) dut_w2 (.bits_i(in2), .sorted_o(out2));

  function automatic int pop(input logic [63:0] v);
    int n = 0;
    foreach (v[i]) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [63:0] therm(input int n);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [9:0] v);
    int n10, n8;
    logic [63:0] head;
    n10 = pop(64'(v));
    n8  = pop(64'(v[7:0]));
    check("R3 full sort w10", 64'(out10), therm(n10));
    check("R2 count w10", 64'(pop(64'(out10))), 64'(n10));
    check("R3 full sort w8", 64'(out8), therm(n8));
    head = 64'(outp3) & 64'h7;
    check("R4 partial head p3", head, therm(n8) & 64'h7);
    check("R2 count p3", 64'(pop(64'(outp3))), 64'(n8));
    check("R7 one pass top", 64'(outp1[0]), 64'(v[7:0] != 8'd0));
    check("R2 count p1", 64'(pop(64'(outp1))), 64'(n8));
    check("R5 zero passes", 64'(outp0), 64'(v[7:0]));
    check("R1 cell", 64'(out2), 64'({v[1] & v[0], v[1] | v[0]}));
  endtask

  task automatic apply(input logic [9:0] v);
    @(posedge clk);
    in10 = v; in8 = v[7:0]; in2 = v[1:0];
    @(negedge clk);
    check_all(v);
  endtask

  initial begin
    in10 = '0; in8 = '0; in2 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: all lanes low
    check("R3 idle zero", 64'(out10), 64'd0);

    // Directed corners
    apply(10'h000); apply(10'h3FF); apply(10'h001); apply(10'h200);
    apply(10'h155); apply(10'h2AA); apply(10'h080); apply(10'h0FF);

    // R6: output follows input with no clock edge in between
    @(posedge clk);
    in10 = 10'h300; #0.5;
    check("R6 comb follow a", 64'(out10), therm(2));
    in10 = 10'h1C1; #0.5;
    check("R6 comb follow b", 64'(out10), therm(4));

    // Exhaustive sweep (w10 and, through the low byte, w8 variants)
    for (int v = 0; v < 1024; v++) apply(10'(v));

    // Constrained random with fixed seed: bias toward sparse and dense words
    void'($urandom(32'd20240611));
    for (int k = 0; k < 300; k++) begin
      logic [9:0] r;
      r = 10'($urandom);
      if (k % 3 == 1) r = r & 10'($urandom);
      if (k % 3 == 2) r = r | 10'($urandom);
      apply(r);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule